// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This peripheral counts down from a 64-bit start value loaded by software, one step per clock. Software reaches it through a single-clock APB-style register port. Two 32-bit words set the start value, and two more words return the live count. Inverting the live count gives a rising timestamp.

A control word starts and stops the counter, picks its mode and masks the interrupt. In reload mode the counter restarts from the start value each time it passes zero, which gives a steady tick. In single mode it stops at zero after one pass. Each pass through zero sets a pending flag, and software clears the flag by writing 1 to it. The interrupt line is the pending flag gated by the unmask bit.

The control word normally sits at offset 0x10. A build parameter moves it to 0x1C for systems that decode it there.

Top module: `dtmr_top`

## Requirements
- R1: After a synchronous reset, the following all read zero and `irq` is low: the start words, the control word, the pending flag and the live count.
- R2: The start value is written and read back as two 32-bit words. The low word is at 0x00 and the high word is at 0x04. Together they form one 64-bit start value, low word in bits 31:0.
- R3: The control word has three bits. Bit 0 is run, bit 1 is mode (0 = reload, 1 = single) and bit 2 is unmask. It reads back as written. When run changes from 0 to 1, the live count takes the 64-bit start value on the next clock.
- R4: While run is set, the live count drops by one each clock. In reload mode with start value N, it passes zero every N+1 clocks. Each pass sets the pending flag and reloads N.
- R5: In single mode the counter sets the pending flag once on reaching zero. It then holds at zero, and the flag is not set again until run is cleared and set once more.
- R6: `irq` is high exactly when the pending flag is set and unmask is 1. A pending flag with unmask 0 leaves `irq` low.
- R7: Writing 1 to bit 0 of the status word at 0x18 clears the pending flag. Writing 0 to it leaves the flag unchanged. Status reads return the flag in bit 0.
- R8: If a pass through zero and a clearing write fall on the same clock, the flag stays set.
- R9: Writing 0 to the control word stops the counter, and the live count holds its value.
- R10: The live count reads at 0x08 (low word) and 0x0C (high word), and writes there are ignored. Writes to unmapped offsets change nothing, and reads of unmapped offsets return zero.
- R11: With the parameter `CTRL_ALT` at 0, the control word is at 0x10 and offset 0x1C is unmapped. With `CTRL_ALT` at 1 it moves to 0x1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the counter and the register port |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data for the selected offset, zero when not selected |
| irq | output | 1 | Interrupt: pending flag gated by unmask |

## Verification
A register write takes effect at the clock edge that ends its access phase. Read data is driven combinationally from the state present during the access phase. The first load of the live count happens one clock after the edge that sets run. In reload mode with start value N, the pending flag first rises N+2 clocks after that edge, and `irq` follows the flag in the same cycle. The bench counts clock edges and records the edge number of every control write. It predicts each live-count, status and `irq` value from the distance between that edge and the edge at which it samples, and it places each clearing write on a chosen edge relative to the predicted pass through zero.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    // Width of a software-visible register word and number of words per count
    localparam int WORD_W   = 32;
    localparam int CNT_WORDS = 2;

    // Offsets whose position is decoded by software
    localparam logic [7:0] OFF_START_BASE = 8'h00;
    localparam logic [7:0] OFF_LIVE_BASE  = 8'h08;
    localparam logic [7:0] OFF_PEND       = 8'h18;
    localparam logic [7:0] OFF_CTRL_STD   = 8'h10;
    localparam logic [7:0] OFF_CTRL_ALT   = 8'h1C;

    typedef enum logic {
        MODE_RELOAD = 1'b0,
        MODE_SINGLE = 1'b1
    } cnt_mode_e;

    // Packed so that run lands in bit 0, mode in bit 1, unmask in bit 2
    typedef struct packed {
        logic      unmask;
        cnt_mode_e mode;
        logic      run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic [7:0] start_off(input int w);
        return OFF_START_BASE + 8'(w * 4);
    endfunction

    function automatic logic [7:0] live_off(input int w);
        return OFF_LIVE_BASE + 8'(w * 4);
    endfunction

    function automatic logic [7:0] ctrl_off(input bit alt);
        return alt ? OFF_CTRL_ALT : OFF_CTRL_STD;
    endfunction

endpackage

// File: rtl/dtmr_regfile.sv
module dtmr_regfile
    import dtmr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter bit CTRL_ALT = 1'b0,
    localparam int CNT_W   = CNT_WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  start_val,
    output ctrl_t             ctrl,
    output logic              clr_req
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(ctrl_off(CTRL_ALT));
    localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(OFF_PEND);

    // One storage word per slice of the start value
    for (genvar w = 0; w < CNT_WORDS; w++) begin : g_start
        localparam logic [ADDR_W-1:0] WORD_A = ADDR_W'(start_off(w));
        always_ff @(posedge clk) begin
            if (rst) begin
                start_val[w*DATA_W +: DATA_W] <= '0;
            end else if (wr_en && addr == WORD_A) begin
                start_val[w*DATA_W +: DATA_W] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en && addr == CTRL_A) begin
            ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    assign clr_req = wr_en && (addr == PEND_A) && wdata[0];

endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter
    import dtmr_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] start_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    logic run_q;
    logic spent;
    logic start;
    logic at_zero;

    assign start   = ctrl.run && !run_q;
    assign at_zero = (count == '0);
    assign expire  = ctrl.run && run_q && at_zero && !spent;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            run_q <= 1'b0;
            spent <= 1'b0;
        end else begin
            run_q <= ctrl.run;
            if (start) begin
                count <= start_val;
                spent <= 1'b0;
            end else if (ctrl.run) begin
                if (at_zero) begin
                    if (ctrl.mode == MODE_RELOAD) begin
                        count <= start_val;
                    end else begin
                        spent <= 1'b1;
                    end
                end else begin
                    count <= count - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dtmr_pending.sv
module dtmr_pending (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic clr_req,
    input  logic unmask,
    output logic pend,
    output logic irq
);

    // A pass through zero outranks a clearing write on the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (expire) begin
            pend <= 1'b1;
        end else if (clr_req) begin
            pend <= 1'b0;
        end
    end

    assign irq = pend && unmask;

endmodule

// File: rtl/dtmr_rdmux.sv
module dtmr_rdmux
    import dtmr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter bit CTRL_ALT = 1'b0,
    localparam int CNT_W   = CNT_WORDS * DATA_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  start_val,
    input  logic [CNT_W-1:0]  count,
    input  ctrl_t             ctrl,
    input  logic              pend,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(ctrl_off(CTRL_ALT));
    localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(OFF_PEND);

    always_comb begin
        rdata = '0;
        for (int w = 0; w < CNT_WORDS; w++) begin
            if (addr == ADDR_W'(start_off(w))) rdata = start_val[w*DATA_W +: DATA_W];
            if (addr == ADDR_W'(live_off(w)))  rdata = count[w*DATA_W +: DATA_W];
        end
        if (addr == CTRL_A) rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
        if (addr == PEND_A) rdata = {{(DATA_W-1){1'b0}}, pend};
    end

endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
    import dtmr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter bit CTRL_ALT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              irq
);

    localparam int CNT_W = CNT_WORDS * DATA_W;

    logic              wr_en;
    logic [CNT_W-1:0]  start_val;
    logic [CNT_W-1:0]  count;
    ctrl_t             ctrl_q;
    logic              clr_req;
    logic              expire;
    logic              pend;
    logic [DATA_W-1:0] rd_word;

    assign wr_en  = psel && penable && pwrite;
    assign prdata = psel ? rd_word : '0;

    dtmr_regfile #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .CTRL_ALT(CTRL_ALT)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (paddr),
        .wdata    (pwdata),
        .start_val(start_val),
        .ctrl     (ctrl_q),
        .clr_req  (clr_req)
    );

    dtmr_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl_q),
        .start_val(start_val),
        .count    (count),
        .expire   (expire)
    );

    dtmr_pending u_pend (
        .clk    (clk),
        .rst    (rst),
        .expire (expire),
        .clr_req(clr_req),
        .unmask (ctrl_q.unmask),
        .pend   (pend),
        .irq    (irq)
    );

    dtmr_rdmux #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .CTRL_ALT(CTRL_ALT)
    ) u_rd (
        .addr     (paddr),
        .start_val(start_val),
        .count    (count),
        .ctrl     (ctrl_q),
        .pend     (pend),
        .rdata    (rd_word)
    );

endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             single,
    input logic [CNT_W-1:0] start_val,
    input logic [CNT_W-1:0] count,
    input logic             expire,
    input logic             clr_req,
    input logic             pend,
    input logic             irq
);

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count == '0 && !pend && !irq));

    a_r3_start_loads: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |=> (count == $past(start_val)));

    a_r4_reload_at_zero: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !single && count == '0) |=> (count == $past(start_val)));

    a_r5_single_holds: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && single && count == '0) |=> (count == '0));

    a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !expire) |=> !pend);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        expire |=> pend);

    a_r9_stopped_holds: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(count));

    a_r6_irq_needs_pend: assert property (@(posedge clk) disable iff (rst)
        irq |-> pend);

endmodule

bind dtmr_top dtmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (ctrl_q.run),
    .single   (ctrl_q.mode),
    .start_val(start_val),
    .count    (count),
    .expire   (expire),
    .clr_req  (clr_req),
    .pend     (pend),
    .irq      (irq)
);

// File: tb/dtmr_top_tb.sv
module dtmr_top_tb;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq;

    int     cyc = 0;
    int     last_wr = 0;
    int     n_checks = 0;
    int     n_fails = 0;
    bit     finished = 1'b0;
    item_t  sb_q[$];
    logic [31:0] obs;
    event   rd_ev;

    dtmr_top u_dut (
        .clk    (clk),
        .rst    (rst),
        .psel   (psel),
        .penable(penable),
        .pwrite (pwrite),
        .paddr  (paddr),
        .pwdata (pwdata),
        .prdata (prdata),
        .irq    (irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Expected live count k edges after the edge that set run
    function automatic logic [63:0] model_cnt(bit single, logic [63:0] n, int k);
        logic [63:0] m;
        m = 64'(k - 1);
        if (single) return (m >= n) ? 64'd0 : n - m;
        return n - (m % (n + 64'd1));
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // All bus tasks start and end on a falling edge
    task automatic wr(logic [7:0] a, logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        last_wr = cyc;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        item_t it;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        obs = prdata;
        -> rd_ev;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    // Live-count read; the sample falls one cycle after entry
    task automatic rd_live(bit hi, bit single, logic [63:0] n, int t_en, string tag);
        logic [63:0] e;
        e = model_cnt(single, n, cyc + 1 - t_en);
        rd(hi ? 8'h0C : 8'h08, hi ? e[63:32] : e[31:0], tag);
    endtask

    task automatic rd_pend_free(logic [63:0] n, int t_en, string tag);
        rd(8'h18, {31'd0, (cyc + 1 - t_en) >= int'(n) + 2}, tag);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Scoreboard monitor
    initial begin
        item_t it;
        forever begin
            @(rd_ev);
            if (sb_q.size() == 0) begin
                check("scoreboard underflow", obs, 32'hx);
            end else begin
                it = sb_q.pop_front();
                check(it.tag, obs, it.exp);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int t_en;
        int t_dis;
        logic [63:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(8'h00, 32'd0, "R1 start low");
        rd(8'h10, 32'd0, "R1 control");
        rd(8'h18, 32'd0, "R1 pending");
        rd(8'h08, 32'd0, "R1 live low");
        check("R1 irq", {31'd0, irq}, 32'd0);

        // R2: start words read back
        wr(8'h00, 32'h1234_5678);
        wr(8'h04, 32'h9ABC_DEF0);
        rd(8'h00, 32'h1234_5678, "R2 start low");
        rd(8'h04, 32'h9ABC_DEF0, "R2 start high");

        // R10: live count read-only, unmapped ignored
        wr(8'h08, 32'h0000_FFFF);
        rd(8'h08, 32'd0, "R10 live write ignored");
        wr(8'h14, 32'hDEAD_BEEF);
        rd(8'h14, 32'd0, "R10 unmapped read zero");
        rd(8'h00, 32'h1234_5678, "R10 unmapped write no effect");

        // R11: 0x1C unmapped with default placement
        wr(8'h1C, 32'h7);
        rd(8'h10, 32'd0, "R11 control untouched");
        rd(8'h1C, 32'd0, "R11 alt offset reads zero");
        rd(8'h0C, 32'd0, "R11 counter not started");

        // R3/R4: reload mode N=5, unmasked
        wr(8'h00, 32'd5);
        wr(8'h04, 32'd0);
        wr(8'h10, 32'h5);
        t_en = last_wr;
        rd(8'h10, 32'h5, "R3 control readback");
        rd_live(1'b0, 1'b0, 64'd5, t_en, "R3 live after start");
        rd_pend_free(64'd5, t_en, "R4 pending before pass");
        rd_live(1'b0, 1'b0, 64'd5, t_en, "R4 live descending");
        rd_live(1'b0, 1'b0, 64'd5, t_en, "R4 live reloaded");
        rd_pend_free(64'd5, t_en, "R4 pending after pass");
        check("R6 irq with pend and unmask", {31'd0, irq}, 32'd1);
        rd_live(1'b0, 1'b0, 64'd5, t_en, "R4 live second period");

        // R7: clearing write one edge after a pass (passes at t_en+7+6j)
        while (((cyc + 2 - (t_en + 7)) % 6) != 1) @(negedge clk);
        wr(8'h18, 32'd0);
        rd(8'h18, 32'd1, "R7 write 0 leaves flag");
        while (((cyc + 2 - (t_en + 7)) % 6) != 1) @(negedge clk);
        wr(8'h18, 32'd1);
        rd(8'h18, 32'd0, "R7 write 1 clears flag");
        check("R6 irq low after clear", {31'd0, irq}, 32'd0);

        // R8: clearing write on the same edge as a pass
        while (((cyc + 2 - (t_en + 7)) % 6) != 0) @(negedge clk);
        wr(8'h18, 32'd1);
        rd(8'h18, 32'd1, "R8 set wins over clear");

        // R9/R6: stop with pending flag set and unmask off
        wr(8'h00, 32'd1000);
        wr(8'h10, 32'h0);
        wr(8'h10, 32'h1);
        t_en = last_wr;
        idle(10);
        wr(8'h10, 32'h0);
        t_dis = last_wr;
        held = model_cnt(1'b0, 64'd1000, t_dis - t_en);
        rd(8'h08, held[31:0], "R9 held after stop");
        idle(15);
        rd(8'h08, held[31:0], "R9 still held");
        rd(8'h18, 32'd1, "R6 pending still set");
        check("R6 masked irq low", {31'd0, irq}, 32'd0);
        wr(8'h18, 32'd1);

        // R5: single mode N=3
        wr(8'h00, 32'd3);
        wr(8'h10, 32'h7);
        t_en = last_wr;
        rd_live(1'b0, 1'b1, 64'd3, t_en, "R5 live after start");
        rd_pend_free(64'd3, t_en, "R5 pending before zero");
        idle(6);
        rd(8'h18, 32'd1, "R5 pending at zero");
        rd(8'h08, 32'd0, "R5 held at zero");
        wr(8'h18, 32'd1);
        idle(20);
        rd(8'h18, 32'd0, "R5 fires once");
        rd(8'h08, 32'd0, "R5 still zero");
        check("R5 irq stays low", {31'd0, irq}, 32'd0);
        wr(8'h10, 32'h0);
        wr(8'h10, 32'h7);
        t_en = last_wr;
        rd_live(1'b0, 1'b1, 64'd3, t_en, "R3 reload on re-enable");

        // R2/R4: 64-bit start value across both words
        wr(8'h10, 32'h0);
        wr(8'h04, 32'd1);
        wr(8'h00, 32'd2);
        wr(8'h10, 32'h1);
        t_en = last_wr;
        rd_live(1'b1, 1'b0, 64'h1_0000_0002, t_en, "R2 live high word");
        rd_live(1'b0, 1'b0, 64'h1_0000_0002, t_en, "R2 live low word");
        rd_live(1'b0, 1'b0, 64'h1_0000_0002, t_en, "R4 low word borrow");
        rd_live(1'b1, 1'b0, 64'h1_0000_0002, t_en, "R4 high word after borrow");

        idle(2);
        finish_run();
    end

endmodule